// File: doc/BRIEF.md
# Late-Write Pipelined-Read Synchronous SRAM

This block models a single-clock synchronous SRAM. Every rising edge samples the address, three chip selects, a load strobe, the write enable and active-low byte strobes. A new access loads an external address. Read data comes out of a registered output stage one edge after the command edge. Write data, and the byte strobes that go with it, are taken one edge after the write command ("late write").

While the load strobe is high, the previous operation continues as a four-beat burst. Only the two low address bits step, and they wrap around the base address. Two deselect kinds exist. A bank deselect, where the secondary selects do not match their configured polarity, turns off both the data driver and the echo-clock enable. A plain deselect, where the primary select is high, turns off only the data driver.

A read issued while the addressed word's late data is being captured returns the fresh data, merged byte by byte. The data bus is split into a write-data port, a read-data port and an output enable.

Top module: `lwsram_top`

## Requirements
- R1: While `rst` is high, and after it is released until a command says otherwise, `rdata_oe` is 0 and `echo_oe` is 0 (the bank-deselect state).
- R2: A command with `ld_n`=0 is a new access only when `cs_n`=0, `cs_b`==CSB_POL (default 1) and `cs_c`==CSC_POL (default 0). It is then a read when `wr_n`=1 and a write when `wr_n`=0.
- R3: For a read sampled at edge t, `rdata` holds the word and `rdata_oe` is 1 after edge t+1.
- R4: For a write sampled at edge t, `wdata` and `bwe_n` are sampled at edge t+1 and stored at the command's address.
- R5: Byte b is `wdata[9b+8:9b]` and is stored only when `bwe_n[b]`=0. A write or write beat with all strobes high stores nothing, but its address is still loaded or stepped.
- R6: A command with `ld_n`=1 after a read or write continues that operation. Beat k uses upper address bits equal to the base and low two bits equal to (base + k) mod 4, so the fifth beat returns to the base.
- R7: A command with `ld_n`=0 and a secondary select mismatched (any `cs_n`) is a bank deselect. After the following edge, `rdata_oe`=0 and `echo_oe`=0.
- R8: A command with `ld_n`=0, matching secondary selects and `cs_n`=1 is a plain deselect. After the following edge, `rdata_oe`=0 and `echo_oe`=1.
- R9: After a write command or write beat, following the next edge, `rdata_oe`=0 and `echo_oe`=1.
- R10: A command with `ld_n`=1 after either kind of deselect keeps that deselect state, whatever the select pins show.
- R11: A read whose address equals that of the late write data sampled on the same edge returns the strobed bytes from `wdata` and the stored bytes elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 10 | External word address |
| cs_n | input | 1 | Primary select, active low |
| cs_b | input | 1 | Secondary select, compared with CSB_POL |
| cs_c | input | 1 | Secondary select, compared with CSC_POL |
| ld_n | input | 1 | Low: load new command; high: continue |
| wr_n | input | 1 | Low: write, high: read |
| bwe_n | input | 4 | Byte strobes, active low, sampled with write data |
| wdata | input | 36 | Write data, one edge after the command |
| rdata | output | 36 | Registered read data |
| rdata_oe | output | 1 | Data driver enable |
| echo_oe | output | 1 | Echo-clock driver enable |

## Verification
Directed patterns come first: single full-strobe writes followed by reads, which expose wrong read latency or late-write alignment. Partial and all-high strobes then separate byte masking from aborts. Burst write and read runs of five beats show the modulo-four wrap. A write followed at once by a read of the same word tells forwarding apart from a stale array read. The two deselect kinds, each followed by continues with scrambled selects, show which driver turns off. A long random mix of loads, continues and deselects over a prefilled region is compared every cycle against a behavioural model.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
   typedef enum logic [1:0] {
      OP_BANKDES = 2'd0,
      OP_DESEL   = 2'd1,
      OP_READ    = 2'd2,
      OP_WRITE   = 2'd3
   } op_e;

   function automatic logic op_is_access(op_e op);
      return (op == OP_READ) || (op == OP_WRITE);
   endfunction
endpackage

// File: rtl/lwsram_cmd.sv
module lwsram_cmd
   import lwsram_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int BURST_BITS = 2,
   parameter bit CSB_POL    = 1'b1,
   parameter bit CSC_POL    = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              cs_n,
   input  logic              cs_b,
   input  logic              cs_c,
   input  logic              ld_n,
   input  logic              wr_n,
   output op_e               cur_op,
   output logic [ADDR_W-1:0] beat_addr
);
   op_e                   prev_q;
   logic [ADDR_W-1:0]     base_q;
   logic [BURST_BITS-1:0] cnt_q, cnt_d;
   logic                  sec_ok;

   assign sec_ok = (cs_b == CSB_POL) && (cs_c == CSC_POL);

   always_comb begin
      cur_op    = prev_q;
      cnt_d     = cnt_q;
      beat_addr = addr;
      if (!ld_n) begin
         if (!sec_ok)    cur_op = OP_BANKDES;
         else if (cs_n)  cur_op = OP_DESEL;
         else if (wr_n)  cur_op = OP_READ;
         else            cur_op = OP_WRITE;
         cnt_d = '0;
      end else begin
         if (op_is_access(prev_q)) cnt_d = cnt_q + 1'b1;
         beat_addr = {base_q[ADDR_W-1:BURST_BITS],
                      base_q[BURST_BITS-1:0] + cnt_d};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= OP_BANKDES;
         cnt_q  <= '0;
         base_q <= '0;
      end else begin
         prev_q <= cur_op;
         cnt_q  <= cnt_d;
         if (!ld_n) base_q <= addr;
      end
   end

   // R6: a continued access keeps the upper bits and steps the low bits by one
   a_r6_burst_step: assert property (@(posedge clk) disable iff (rst)
      (ld_n && op_is_access(cur_op)) |->
         ((beat_addr[ADDR_W-1:BURST_BITS] == $past(beat_addr[ADDR_W-1:BURST_BITS])) &&
          (beat_addr[BURST_BITS-1:0] == BURST_BITS'($past(beat_addr[BURST_BITS-1:0]) + 1'b1))));
endmodule

// File: rtl/lwsram_wstage.sv
module lwsram_wstage
   import lwsram_pkg::*;
#(
   parameter int ADDR_W    = 10,
   parameter int NUM_BYTES = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  op_e                  cur_op,
   input  logic [ADDR_W-1:0]    beat_addr,
   input  logic [NUM_BYTES-1:0] bwe_n,
   output logic                 wr_valid,
   output logic [ADDR_W-1:0]    wr_addr,
   output logic [NUM_BYTES-1:0] wr_be
);
   always_ff @(posedge clk) begin
      if (rst) begin
         wr_valid <= 1'b0;
         wr_addr  <= '0;
      end else begin
         wr_valid <= (cur_op == OP_WRITE);
         wr_addr  <= beat_addr;
      end
   end

   assign wr_be = {NUM_BYTES{wr_valid}} & ~bwe_n;
endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
   parameter int ADDR_W    = 10,
   parameter int NUM_BYTES = 4,
   parameter int BYTE_W    = 9,
   parameter int DEPTH     = 1024,
   localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
   input  logic                 clk,
   input  logic [NUM_BYTES-1:0] wr_be,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    rd_addr,
   output logic [DATA_W-1:0]    rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] arr_word, merged;
   logic              same_addr;

   always_ff @(posedge clk) begin
      for (int b = 0; b < NUM_BYTES; b++) begin
         if (wr_be[b]) mem[wr_addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
      end
   end

   assign arr_word  = mem[rd_addr];
   assign same_addr = (wr_addr == rd_addr);

   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_fwd
      assign merged[g*BYTE_W +: BYTE_W] = (wr_be[g] && same_addr) ?
                                          wdata[g*BYTE_W +: BYTE_W] :
                                          arr_word[g*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= merged;
   end
endmodule

// File: rtl/lwsram_top.sv
module lwsram_top
   import lwsram_pkg::*;
#(
   parameter int NUM_BYTES = 4,
   parameter int BYTE_W    = 9,
   parameter int DEPTH     = 1024,
   parameter bit CSB_POL   = 1'b1,
   parameter bit CSC_POL   = 1'b0,
   localparam int DATA_W     = NUM_BYTES * BYTE_W,
   localparam int ADDR_W     = $clog2(DEPTH),
   localparam int BURST_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 cs_n,
   input  logic                 cs_b,
   input  logic                 cs_c,
   input  logic                 ld_n,
   input  logic                 wr_n,
   input  logic [NUM_BYTES-1:0] bwe_n,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   output logic                 rdata_oe,
   output logic                 echo_oe
);
   if (DEPTH != (1 << ADDR_W)) begin : g_chk_depth
      $error("DEPTH must be a power of two");
   end
   if (ADDR_W <= BURST_BITS) begin : g_chk_aw
      $error("address must be wider than the burst field");
   end
   if (BYTE_W < 1 || NUM_BYTES < 1) begin : g_chk_bytes
      $error("byte geometry must be non-zero");
   end

   op_e                  cur_op;
   logic [ADDR_W-1:0]    beat_addr, wr_addr;
   logic                 wr_valid;
   logic [NUM_BYTES-1:0] wr_be;
   logic [DATA_W-1:0]    arr_q;
   logic                 s1_rd, s1_echo;

   lwsram_cmd #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS),
                .CSB_POL(CSB_POL), .CSC_POL(CSC_POL)) i_cmd (
      .clk(clk), .rst(rst), .addr(addr), .cs_n(cs_n), .cs_b(cs_b), .cs_c(cs_c),
      .ld_n(ld_n), .wr_n(wr_n), .cur_op(cur_op), .beat_addr(beat_addr));

   lwsram_wstage #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) i_wstage (
      .clk(clk), .rst(rst), .cur_op(cur_op), .beat_addr(beat_addr), .bwe_n(bwe_n),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_be(wr_be));

   lwsram_array #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W),
                  .DEPTH(DEPTH)) i_array (
      .clk(clk), .wr_be(wr_be), .wr_addr(wr_addr), .wdata(wdata),
      .rd_en(cur_op == OP_READ), .rd_addr(beat_addr), .rd_data(arr_q));

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_rd    <= 1'b0;
         s1_echo  <= 1'b0;
         rdata_oe <= 1'b0;
         echo_oe  <= 1'b0;
         rdata    <= '0;
      end else begin
         s1_rd    <= (cur_op == OP_READ);
         s1_echo  <= (cur_op != OP_BANKDES);
         rdata_oe <= s1_rd;
         echo_oe  <= s1_echo;
         rdata    <= arr_q;
      end
   end

   logic port_sec;
   assign port_sec = (cs_b == CSB_POL) && (cs_c == CSC_POL);

   // R3: a loaded read drives the bus after the following edge
   a_r3_read_drives: assert property (@(posedge clk) disable iff (rst)
      (!ld_n && port_sec && !cs_n && wr_n) |=> ##1 rdata_oe);
   // R7: bank deselect turns off both drivers
   a_r7_bank_off: assert property (@(posedge clk) disable iff (rst)
      (!ld_n && !port_sec) |=> ##1 (!rdata_oe && !echo_oe));
   // R8: plain deselect keeps the echo enable
   a_r8_plain_off: assert property (@(posedge clk) disable iff (rst)
      (!ld_n && port_sec && cs_n) |=> ##1 (!rdata_oe && echo_oe));
   // R9: write command releases the data bus
   a_r9_write_hiz: assert property (@(posedge clk) disable iff (rst)
      (!ld_n && port_sec && !cs_n && !wr_n) |=> ##1 (!rdata_oe && echo_oe));
   // R4: late data is pending only behind a write command or beat
   a_r4_pending_src: assert property (@(posedge clk) disable iff (rst)
      wr_valid |-> ($past(cur_op) == OP_WRITE));
   // R5: all strobes high stores nothing
   a_r5_abort_quiet: assert property (@(posedge clk) disable iff (rst)
      (&bwe_n) |-> (wr_be == '0));
endmodule

// File: tb/test_lwsram_top.sv
module test_lwsram_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam int DW = 36;

   logic          clk = 1'b0;
   logic          rst;
   logic [AW-1:0] addr;
   logic          cs_n, cs_b, cs_c, ld_n, wr_n;
   logic [3:0]    bwe_n;
   logic [DW-1:0] wdata;
   logic [DW-1:0] rdata;
   logic          rdata_oe, echo_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   lwsram_top i_lwsram_top (
      .clk(clk), .rst(rst), .addr(addr), .cs_n(cs_n), .cs_b(cs_b), .cs_c(cs_c),
      .ld_n(ld_n), .wr_n(wr_n), .bwe_n(bwe_n), .wdata(wdata),
      .rdata(rdata), .rdata_oe(rdata_oe), .echo_oe(echo_oe));

   int    checks = 0;
   int    errors = 0;
   string tag = "R1";

   // behavioural model: 0 bank deselect, 1 deselect, 2 read, 3 write
   logic [DW-1:0] m_mem [1024];
   int            m_op, m_cnt;
   logic [AW-1:0] m_base, m_wa;
   bit            m_wv, s1_rd, s1_echo, e_oe, e_echo;
   logic [DW-1:0] s1_data, e_data;

   task automatic model_edge();
      logic [AW-1:0] a;
      if (rst) begin
         m_op = 0; m_cnt = 0; m_base = '0; m_wv = 0;
         s1_rd = 0; s1_echo = 0; e_oe = 0; e_echo = 0;
         return;
      end
      e_oe = s1_rd; e_echo = s1_echo; e_data = s1_data;
      if (m_wv)
         for (int b = 0; b < 4; b++)
            if (!bwe_n[b]) m_mem[m_wa][b*9 +: 9] = wdata[b*9 +: 9];
      if (!ld_n) begin
         if (!(cs_b == 1'b1 && cs_c == 1'b0)) m_op = 0;
         else if (cs_n) m_op = 1;
         else m_op = wr_n ? 2 : 3;
         m_base = addr; m_cnt = 0; a = addr;
      end else begin
         if (m_op >= 2) m_cnt = (m_cnt + 1) % 4;
         a = {m_base[AW-1:2], 2'(m_base[1:0] + 2'(m_cnt))};
      end
      s1_rd = (m_op == 2);
      s1_echo = (m_op != 0);
      if (s1_rd) s1_data = m_mem[a];
      m_wv = (m_op == 3);
      m_wa = a;
   endtask

   task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk("rdata_oe", DW'(rdata_oe), DW'(e_oe));
      chk("echo_oe", DW'(echo_oe), DW'(e_echo));
      if (e_oe) chk("rdata", rdata, e_data);
   endtask

   task automatic cmd_new(bit wr, logic [AW-1:0] a);
      ld_n = 0; cs_n = 0; cs_b = 1; cs_c = 0; wr_n = !wr; addr = a;
   endtask
   task automatic cmd_cont();
      ld_n = 1; cs_n = $urandom; cs_b = $urandom; cs_c = $urandom; wr_n = $urandom;
      addr = AW'($urandom);
   endtask
   task automatic cmd_bdes();
      ld_n = 0; cs_n = $urandom; cs_b = 0; cs_c = $urandom; wr_n = $urandom;
   endtask
   task automatic cmd_des();
      ld_n = 0; cs_n = 1; cs_b = 1; cs_c = 0; wr_n = $urandom;
   endtask
   task automatic put(logic [DW-1:0] d, logic [3:0] be);
      wdata = d; bwe_n = be;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 1024; i++) m_mem[i] = '0;
      rst = 1; cmd_des(); ld_n = 1; put('0, 4'hF); addr = '0;
      tag = "R1";
      tick(); tick();
      rst = 0;
      ld_n = 1;
      tick(); tick();

      tag = "R6";  // prefill 0..15 with bursts, fifth beat rewrites base
      for (int g = 0; g < 4; g++) begin
         cmd_new(1, AW'(g*4 + 1)); put('0, 4'hF); tick();
         for (int k = 0; k < 4; k++) begin
            cmd_cont(); put(DW'(36'h100000000 * g + 36'h11 * (k + 1)), 4'h0); tick();
         end
         cmd_des(); put(36'hABCDE0000 + DW'(g), 4'h0); tick();
      end
      cmd_new(0, 10'd6); put('0, 4'hF); tick();
      for (int k = 0; k < 5; k++) begin cmd_cont(); tick(); end
      cmd_des(); tick(); tick();

      tag = "R2";
      cmd_new(1, 10'd20); put('0, 4'hF); tick();
      cmd_new(0, 10'd20); put(36'h123456789, 4'h0); tick();
      tag = "R3";
      cmd_des(); tick(); tick();
      tag = "R4";
      cmd_new(1, 10'd21); tick();
      cmd_des(); put(36'hFEDCBA987, 4'h0); tick();
      cmd_new(0, 10'd21); put(36'h0, 4'h0); tick();
      cmd_des(); tick(); tick();

      tag = "R5";
      cmd_new(1, 10'd21); put('0, 4'hF); tick();
      cmd_cont(); put(36'h000000000, 4'b1010); tick();
      cmd_des(); put(36'hFFFFFFFFF, 4'hF); tick();
      cmd_new(0, 10'd21); tick();
      cmd_cont(); tick();
      cmd_des(); tick(); tick();

      tag = "R11";
      cmd_new(1, 10'd3); put('0, 4'hF); tick();
      cmd_new(0, 10'd3); put(36'h5A5A5A5A5, 4'b0110); tick();
      cmd_des(); tick(); tick();

      tag = "R9";
      cmd_new(0, 10'd3); tick();
      cmd_new(1, 10'd4); tick();
      cmd_cont(); put(36'h1, 4'h0); tick();
      cmd_des(); put(36'h2, 4'h0); tick(); tick();

      tag = "R7";
      cmd_bdes(); tick(); tick();
      tag = "R10";
      for (int k = 0; k < 4; k++) begin cmd_cont(); tick(); end
      tag = "R8";
      cmd_des(); tick(); tick();
      tag = "R10";
      for (int k = 0; k < 4; k++) begin cmd_cont(); tick(); end

      tag = "mixed";
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 45) cmd_cont();
         else if (r < 52) cmd_bdes();
         else if (r < 59) cmd_des();
         else cmd_new(r[0], AW'($urandom_range(0, 15)));
         put({$urandom, 4'($urandom)}, ($urandom_range(0, 4) == 0) ? 4'hF : 4'($urandom));
         tick();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule